// File: doc/BRIEF.md
# Program Memory Access Bridge

This block lets a core with a 16-bit data path reach a program memory whose words are 24 bits wide, through one synchronous memory port. Three requesters share that port: instruction fetch, a table path that reads or writes single bytes or 16-bit words anywhere in program space (including the top byte of a program word), and a read-only window that maps a page of program space into the upper half of data space.

For each granted request the bridge builds the program word address, drives the memory port in the same cycle and, one cycle later, returns the selected bits zero-extended to 24 bits with a valid pulse and a source tag. Two page registers written by the core steer the address building: an 8-bit table page and a 10-bit window page. Fetch has top priority, then the table path, then the window. A waiting requester sees a stall signal and holds its request until it is served.

Top module: `pgm_bridge`

## Requirements
- R1: A fetch request drives `mem_addr = {1'b0, fetch_pc}` (program bit 23 and byte bit 0 are zero) and returns the full 24-bit word with `rsp_src = 1`.
- R2: A table access drives `mem_addr = {tpage, tbl_ea[15:1]}`, so table page bit 7 is `mem_addr[22]` and selects configuration space (1) or user space (0).
- R3: A table read returns, tagged `rsp_src = 2`: bits 23:16 when `tbl_hi = 1`; else bits 7:0 (`tbl_ea[0] = 0`) or 15:8 (`tbl_ea[0] = 1`) when `tbl_byte = 1`; else bits 15:0; always zero-extended.
- R4: A table write sets `mem_we` with byte enables `100` for the top byte, `001`/`010` for byte lane 0/1 and `011` for a word, placing the byte or word in the enabled lane(s) of `mem_wdata`.
- R5: A window request is claimed only when `win_ea[15] = 1` and window page bit 9 is 1; otherwise it causes no memory access, no stall and no response.
- R6: A window read drives `mem_addr = {1'b0, wpage[7:0], win_ea[14:1]}`, so only user space is reachable.
- R7: A window read returns bits 15:0 when window page bit 8 is 0 and bits 23:16 zero-extended when it is 1, tagged `rsp_src = 3`.
- R8: A window write inside the claimed range causes no memory write and raises `win_err` for exactly the next cycle; one outside the range raises nothing.
- R9: Priority is fetch, then table, then window; a requester that is not granted sees its stall output high, and fetch never stalls.
- R10: Every granted read yields exactly one `rsp_valid` pulse in the following cycle; writes yield none.
- R11: After reset both page registers are zero, so the window is disabled and table accesses target user page 0.
- R12: A page register write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpage_we | input | 1 | Table page register write strobe |
| tpage_wdata | input | 8 | Table page write value |
| wpage_we | input | 1 | Window page register write strobe |
| wpage_wdata | input | 10 | Window page write value |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_pc | input | 22 | Program counter bits 22:1 |
| tbl_req | input | 1 | Table access request |
| tbl_we | input | 1 | Table access is a write |
| tbl_byte | input | 1 | Table access is a byte access |
| tbl_hi | input | 1 | Table access targets program bits 23:16 |
| tbl_ea | input | 16 | Table effective address |
| tbl_wdata | input | 16 | Table write data |
| tbl_stall | output | 1 | Table request waiting |
| win_req | input | 1 | Data access possibly in the window |
| win_we | input | 1 | Data access is a write |
| win_ea | input | 15 | Data effective address bits 15:1 |
| win_stall | output | 1 | Window read waiting |
| win_err | output | 1 | One-cycle pulse after a window write |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write |
| mem_addr | output | 23 | Program word address |
| mem_be | output | 3 | Byte enables of the program word |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, one cycle after enable |
| rsp_valid | output | 1 | Read data valid |
| rsp_src | output | 2 | Source tag: 1 fetch, 2 table, 3 window |
| rsp_data | output | 24 | Selected read bits, zero-extended |

## Verification
The assertions assume a requester keeps its request and attributes steady while its stall output is high, and that the memory returns read data on the cycle after an enabled read. The bench drives every request for a whole cycle, keeps stalled requests unchanged until their grant, and its memory stub is a registered array, so both assumptions hold. Corner cases covered are the disabled window, the configuration page bit, each byte lane and the three-way contention.

// File: rtl/pgm_bridge_pkg.sv
package pgm_bridge_pkg;
    localparam int PROG_W   = 24;
    localparam int DATA_W   = 16;
    localparam int TPAG_W   = 8;
    localparam int WPAG_W   = 10;
    localparam int BYTE_W   = 8;
    localparam int MA_W     = PROG_W - 1;
    localparam int NLANE    = PROG_W / BYTE_W;
    localparam int WPG_EN   = WPAG_W - 1;
    localparam int WPG_HI   = WPAG_W - 2;
    localparam int WOFF_W   = DATA_W - 2;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_FETCH = 2'd1,
        SRC_TBL   = 2'd2,
        SRC_WIN   = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        LANE_FULL,
        LANE_W0,
        LANE_B0,
        LANE_B1,
        LANE_B2
    } lane_e;

    function automatic logic [PROG_W-1:0] lane_pick(lane_e lane, logic [PROG_W-1:0] w);
        logic [PROG_W-1:0] r;
        r = '0;
        case (lane)
            LANE_FULL: r = w;
            LANE_W0:   r[DATA_W-1:0] = w[DATA_W-1:0];
            LANE_B0:   r[BYTE_W-1:0] = w[BYTE_W-1:0];
            LANE_B1:   r[BYTE_W-1:0] = w[2*BYTE_W-1:BYTE_W];
            default:   r[BYTE_W-1:0] = w[3*BYTE_W-1:2*BYTE_W];
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pgm_page_regs.sv
module pgm_page_regs
    import pgm_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tpage_we,
    input  logic [TPAG_W-1:0] tpage_wdata,
    input  logic              wpage_we,
    input  logic [WPAG_W-1:0] wpage_wdata,
    output logic [TPAG_W-1:0] tpage,
    output logic [WPAG_W-1:0] wpage
);
    typedef struct packed {
        logic [TPAG_W-1:0] tp;
        logic [WPAG_W-1:0] wp;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (tpage_we) pg_d.tp = tpage_wdata;
        if (wpage_we) pg_d.wp = wpage_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign tpage = pg_q.tp;
    assign wpage = pg_q.wp;

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tpage_we) && !$past(wpage_we)) |-> ($stable(tpage) && $stable(wpage))); // R12
endmodule

// File: rtl/pgm_addr_gen.sv
module pgm_addr_gen
    import pgm_bridge_pkg::*;
(
    input  logic [TPAG_W-1:0] tpage,
    input  logic [WPAG_W-1:0] wpage,
    input  logic [MA_W-2:0]   fetch_pc,
    input  logic              tbl_byte,
    input  logic              tbl_hi,
    input  logic [DATA_W-1:0] tbl_ea,
    input  logic [DATA_W-1:0] tbl_wdata,
    input  logic [DATA_W-1:1] win_ea,
    output logic [MA_W-1:0]   fetch_wa,
    output logic [MA_W-1:0]   tbl_wa,
    output lane_e             tbl_lane,
    output logic [NLANE-1:0]  tbl_be,
    output logic [PROG_W-1:0] tbl_wd,
    output logic              win_hit,
    output logic [MA_W-1:0]   win_wa,
    output lane_e             win_lane
);
    logic [BYTE_W-1:0] wbyte;

    always_comb begin
        wbyte    = tbl_wdata[BYTE_W-1:0];
        fetch_wa = {1'b0, fetch_pc};
        tbl_wa   = {tpage, tbl_ea[DATA_W-1:1]};
        if (tbl_hi) begin
            tbl_lane = LANE_B2;
            tbl_be   = 3'b100;
            tbl_wd   = {wbyte, {DATA_W{1'b0}}};
        end else if (tbl_byte) begin
            tbl_lane = tbl_ea[0] ? LANE_B1 : LANE_B0;
            tbl_be   = tbl_ea[0] ? 3'b010 : 3'b001;
            tbl_wd   = {NLANE{wbyte}};
        end else begin
            tbl_lane = LANE_W0;
            tbl_be   = 3'b011;
            tbl_wd   = {{(PROG_W-DATA_W){1'b0}}, tbl_wdata};
        end
        win_hit  = wpage[WPG_EN] & win_ea[DATA_W-1];
        win_wa   = {1'b0, wpage[TPAG_W-1:0], win_ea[DATA_W-2:1]};
        win_lane = wpage[WPG_HI] ? LANE_B2 : LANE_W0;
    end
endmodule

// File: rtl/pgm_arb.sv
module pgm_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_req,
    input  logic tbl_req,
    input  logic win_rd,
    output logic gnt_fetch,
    output logic gnt_tbl,
    output logic gnt_win,
    output logic tbl_stall,
    output logic win_stall
);
    always_comb begin
        gnt_fetch = fetch_req;
        gnt_tbl   = tbl_req & ~fetch_req;
        gnt_win   = win_rd & ~fetch_req & ~tbl_req;
        tbl_stall = tbl_req & ~gnt_tbl;
        win_stall = win_rd & ~gnt_win;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_fetch, gnt_tbl, gnt_win})); // R9
    AST_STALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_stall || win_stall) |-> (fetch_req || tbl_req)); // R9
endmodule

// File: rtl/pgm_bridge.sv
module pgm_bridge
    import pgm_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tpage_we,
    input  logic [7:0]        tpage_wdata,
    input  logic              wpage_we,
    input  logic [9:0]        wpage_wdata,
    input  logic              fetch_req,
    input  logic [22:1]       fetch_pc,
    input  logic              tbl_req,
    input  logic              tbl_we,
    input  logic              tbl_byte,
    input  logic              tbl_hi,
    input  logic [15:0]       tbl_ea,
    input  logic [15:0]       tbl_wdata,
    output logic              tbl_stall,
    input  logic              win_req,
    input  logic              win_we,
    input  logic [15:1]       win_ea,
    output logic              win_stall,
    output logic              win_err,
    output logic              mem_en,
    output logic              mem_we,
    output logic [22:0]       mem_addr,
    output logic [2:0]        mem_be,
    output logic [23:0]       mem_wdata,
    input  logic [23:0]       mem_rdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_src,
    output logic [23:0]       rsp_data
);
    typedef struct packed {
        logic  vld;
        src_e  src;
        lane_e lane;
        logic  err;
    } st_t;

    st_t st_d, st_q;

    logic [TPAG_W-1:0] tpage;
    logic [WPAG_W-1:0] wpage;
    logic [MA_W-1:0]   fetch_wa, tbl_wa, win_wa;
    lane_e             tbl_lane, win_lane;
    logic [NLANE-1:0]  tbl_be;
    logic [PROG_W-1:0] tbl_wd;
    logic              win_hit, win_rd;
    logic              gnt_fetch, gnt_tbl, gnt_win;

    pgm_page_regs u_pages (
        .clk(clk), .rst_n(rst_n),
        .tpage_we(tpage_we), .tpage_wdata(tpage_wdata),
        .wpage_we(wpage_we), .wpage_wdata(wpage_wdata),
        .tpage(tpage), .wpage(wpage)
    );

    pgm_addr_gen u_addr (
        .tpage(tpage), .wpage(wpage), .fetch_pc(fetch_pc),
        .tbl_byte(tbl_byte), .tbl_hi(tbl_hi), .tbl_ea(tbl_ea), .tbl_wdata(tbl_wdata),
        .win_ea(win_ea),
        .fetch_wa(fetch_wa), .tbl_wa(tbl_wa), .tbl_lane(tbl_lane), .tbl_be(tbl_be),
        .tbl_wd(tbl_wd), .win_hit(win_hit), .win_wa(win_wa), .win_lane(win_lane)
    );

    assign win_rd = win_req & ~win_we & win_hit;

    pgm_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .tbl_req(tbl_req), .win_rd(win_rd),
        .gnt_fetch(gnt_fetch), .gnt_tbl(gnt_tbl), .gnt_win(gnt_win),
        .tbl_stall(tbl_stall), .win_stall(win_stall)
    );

    always_comb begin
        st_d      = st_q;
        mem_en    = gnt_fetch | gnt_tbl | gnt_win;
        mem_we    = gnt_tbl & tbl_we;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        st_d.src  = SRC_NONE;
        st_d.lane = LANE_FULL;
        if (gnt_fetch) begin
            mem_addr  = fetch_wa;
            mem_be    = '1;
            st_d.src  = SRC_FETCH;
            st_d.lane = LANE_FULL;
        end else if (gnt_tbl) begin
            mem_addr  = tbl_wa;
            mem_be    = tbl_be;
            mem_wdata = tbl_wd;
            st_d.src  = SRC_TBL;
            st_d.lane = tbl_lane;
        end else if (gnt_win) begin
            mem_addr  = win_wa;
            mem_be    = '1;
            st_d.src  = SRC_WIN;
            st_d.lane = win_lane;
        end
        st_d.vld = mem_en & ~mem_we;
        st_d.err = win_req & win_we & win_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{vld: 1'b0, src: SRC_NONE, lane: LANE_FULL, err: 1'b0};
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_src   = st_q.vld ? st_q.src : SRC_NONE;
    assign rsp_data  = st_q.vld ? lane_pick(st_q.lane, mem_rdata) : '0;
    assign win_err   = st_q.err;

    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> rsp_valid); // R10
    AST_RSP_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_en && !mem_we)); // R10
    AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (mem_en && !mem_we && !mem_addr[MA_W-1])); // R1
    AST_WIN_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && !win_we && win_hit && !win_stall) |-> !mem_addr[MA_W-1]); // R6
    AST_WIN_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_err |-> $past(win_req && win_we)); // R8
    AST_WIN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && win_we && !tbl_req) |-> !mem_we); // R8
endmodule

// File: tb/pgm_bridge_test.sv
module pgm_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tpage_we = 0, wpage_we = 0;
    logic [7:0]  tpage_wdata = 0;
    logic [9:0]  wpage_wdata = 0;
    logic        fetch_req = 0;
    logic [22:1] fetch_pc = 0;
    logic        tbl_req = 0, tbl_we = 0, tbl_byte = 0, tbl_hi = 0;
    logic [15:0] tbl_ea = 0, tbl_wdata = 0;
    logic        tbl_stall;
    logic        win_req = 0, win_we = 0;
    logic [15:1] win_ea = 0;
    logic        win_stall, win_err;
    logic        mem_en, mem_we;
    logic [22:0] mem_addr;
    logic [2:0]  mem_be;
    logic [23:0] mem_wdata, mem_rdata;
    logic        rsp_valid;
    logic [1:0]  rsp_src;
    logic [23:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pgm_bridge uut (.*);

    logic [23:0] store [256];

    function automatic logic [23:0] pat(int i);
        logic [7:0] b;
        b = 8'(i);
        return {b ^ 8'h5A, ~b, b + 8'h11};
    endfunction

    initial for (int i = 0; i < 256; i++) store[i] = pat(i);

    always_ff @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int l = 0; l < 3; l++)
                    if (mem_be[l]) store[mem_addr[7:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
            end
            mem_rdata <= store[mem_addr[7:0]];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        tpage_we = 0; wpage_we = 0; fetch_req = 0; tbl_req = 0; tbl_we = 0;
        tbl_byte = 0; tbl_hi = 0; win_req = 0; win_we = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_pages(input logic [7:0] t, input logic [9:0] w);
        tpage_we = 1; tpage_wdata = t; wpage_we = 1; wpage_wdata = w;
        step();
        idle();
    endtask

    task automatic tbl_read(input logic [15:0] ea, input logic bt, input logic hi,
                            input logic [7:0] tp, input logic [23:0] exp, input string tag);
        tbl_req = 1; tbl_we = 0; tbl_byte = bt; tbl_hi = hi; tbl_ea = ea;
        #1;
        chk({tag, " addr"}, 32'(mem_addr), 32'({tp, ea[15:1]}));
        step();
        idle();
        chk({tag, " valid"}, 32'(rsp_valid), 1);
        chk({tag, " src"}, 32'(rsp_src), 2);
        chk({tag, " data"}, 32'(rsp_data), 32'(exp));
    endtask

    task automatic t_reset();
        win_req = 1; win_ea = 15'h4002;
        #1;
        chk("R11 R5 window off after reset: no access", 32'(mem_en), 0);
        chk("R5 no stall when window off", 32'(win_stall), 0);
        step();
        idle();
        chk("R5 no response when window off", 32'(rsp_valid), 0);
        tbl_read(16'h0010, 0, 0, 8'h00, {8'h0, pat(8'h08) & 24'hFFFF}, "R11 R2 table page 0");
    endtask

    task automatic t_fetch();
        logic [22:1] pc;
        pc = 22'h3F809B;
        fetch_req = 1; fetch_pc = pc;
        #1;
        chk("R1 fetch addr", 32'(mem_addr), 32'({1'b0, pc}));
        chk("R9 fetch never stalls", 32'(mem_en), 1);
        step();
        idle();
        chk("R1 fetch src", 32'(rsp_src), 1);
        chk("R1 fetch full word", 32'(rsp_data), 32'(pat(8'h9B)));
        chk("R10 single pulse", 32'(rsp_valid), 1);
        step();
        chk("R10 pulse ends", 32'(rsp_valid), 0);
    endtask

    task automatic t_table_read();
        set_pages(8'h81, 10'h000);
        tbl_read(16'h0021, 1, 0, 8'h81, {16'h0, pat(8'h10)[15:8]}, "R3 R12 byte1 cfg");
        chk("R2 cfg page bit", 32'(8'h81 >> 7), 1);
        tbl_read(16'h0020, 1, 0, 8'h81, {16'h0, pat(8'h10)[7:0]}, "R3 byte0");
        tbl_read(16'h0020, 0, 0, 8'h81, {8'h0, pat(8'h10)[15:0]}, "R3 word");
        tbl_read(16'h0020, 0, 1, 8'h81, {16'h0, pat(8'h10)[23:16]}, "R3 top byte");
    endtask

    task automatic t_table_write();
        set_pages(8'h00, 10'h000);
        tbl_req = 1; tbl_we = 1; tbl_byte = 1; tbl_ea = 16'h0031; tbl_wdata = 16'h00C3;
        #1;
        chk("R4 byte1 enables", 32'(mem_be), 3'b010);
        chk("R4 write strobe", 32'(mem_we), 1);
        chk("R4 byte1 lane data", 32'(mem_wdata[15:8]), 8'hC3);
        step();
        idle();
        chk("R10 no response for write", 32'(rsp_valid), 0);
        tbl_req = 1; tbl_we = 1; tbl_hi = 1; tbl_ea = 16'h0030; tbl_wdata = 16'h007E;
        #1;
        chk("R4 top enables", 32'(mem_be), 3'b100);
        step();
        idle();
        tbl_req = 1; tbl_we = 1; tbl_ea = 16'h0032; tbl_wdata = 16'hBEEF;
        #1;
        chk("R4 word enables", 32'(mem_be), 3'b011);
        step();
        idle();
        tbl_read(16'h0030, 0, 0, 8'h00, {8'h0, 8'hC3, pat(8'h18)[7:0]}, "R4 byte readback");
        tbl_read(16'h0030, 0, 1, 8'h00, 24'h00007E, "R4 top readback");
        tbl_read(16'h0032, 0, 0, 8'h00, 24'h00BEEF, "R4 word readback");
    endtask

    task automatic win_read(input logic [15:1] ea, input logic [7:0] pg, input logic [23:0] exp,
                            input string tag);
        win_req = 1; win_we = 0; win_ea = ea;
        #1;
        chk({tag, " addr R6"}, 32'(mem_addr), 32'({1'b0, pg, ea[14:1]}));
        step();
        idle();
        chk({tag, " src R7"}, 32'(rsp_src), 3);
        chk({tag, " data R7"}, 32'(rsp_data), 32'(exp));
    endtask

    task automatic t_window();
        set_pages(8'h00, 10'h342);
        win_read({1'b1, 14'h0023}, 8'h42, {16'h0, pat(8'h23)[23:16]}, "R7 upper");
        set_pages(8'h00, 10'h242);
        win_read({1'b1, 14'h0023}, 8'h42, {8'h0, pat(8'h23)[15:0]}, "R7 lower");
        win_req = 1; win_ea = {1'b0, 14'h0023};
        #1;
        chk("R5 low half not claimed", 32'(mem_en), 0);
        step();
        idle();
        chk("R5 low half no response", 32'(rsp_valid), 0);
    endtask

    task automatic t_win_write();
        win_req = 1; win_we = 1; win_ea = {1'b1, 14'h0001};
        #1;
        chk("R8 no memory write", 32'(mem_en), 0);
        step();
        idle();
        chk("R8 error raised", 32'(win_err), 1);
        step();
        chk("R8 error one cycle", 32'(win_err), 0);
        win_req = 1; win_we = 1; win_ea = {1'b0, 14'h0001};
        step();
        idle();
        chk("R8 no error outside window", 32'(win_err), 0);
    endtask

    task automatic t_priority();
        fetch_req = 1; fetch_pc = 22'h000005;
        tbl_req = 1; tbl_ea = 16'h000C;
        win_req = 1; win_ea = {1'b1, 14'h0007};
        #1;
        chk("R9 table stalls under fetch", 32'(tbl_stall), 1);
        chk("R9 window stalls under fetch", 32'(win_stall), 1);
        chk("R9 fetch owns port", 32'(mem_addr), 32'h5);
        step();
        fetch_req = 0;
        #1;
        chk("R9 fetch response", 32'(rsp_src), 1);
        chk("R9 table granted", 32'(tbl_stall), 0);
        chk("R9 window still stalls", 32'(win_stall), 1);
        step();
        tbl_req = 0;
        #1;
        chk("R9 table response", 32'(rsp_data), 32'({8'h0, pat(8'h06)[15:0]}));
        chk("R9 window granted", 32'(win_stall), 0);
        step();
        idle();
        chk("R9 window response", 32'(rsp_src), 3);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R11 no response at reset", 32'(rsp_valid), 0);
        chk("R11 no error at reset", 32'(win_err), 0);
        t_reset();
        t_fetch();
        t_table_read();
        t_table_write();
        t_window();
        t_win_write();
        t_priority();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule